// File: doc/BRIEF.md
# Threshold-Neuron XOR Classifier

This block decides, for two signed fixed-point samples, whether exactly one of them is "large". It does this with a tiny fixed network of threshold neurons rather than with a logic gate. The first stage binarizes each sample by comparing its magnitude with one half. The magnitude comes from a sign-controlled pass-or-negate step followed by an unsigned compare. A second stage holds two hidden neurons with fixed weights. One behaves like an OR of the two bits and the other like a NAND. A final neuron fires only when both hidden neurons fire.

Each sample is a 12-bit two's-complement word with 10 fractional bits, so the nominal working range is -1.0 to +1.0. When a sample is presented with its valid strobe, the binary answer appears on a registered output one clock later, together with an output-valid flag. There are no trainable weights and no configuration. Every weight and threshold is a constant.

Top module: `xorn_classifier`

## Requirements
- R1: A synchronous active-high reset clears both `y` and `outValid` to 0 on the clock edge where it is sampled.
- R2: The input stage maps a sample to 1 when its magnitude is at least 0.5 (code 0x200 with 10 fractional bits), and to 0 otherwise.
- R3: The boundary codes +0.5 (0x200) and -0.5 (0xE00) both map to 1. The codes just inside them, 0x1FF and 0xE01, both map to 0.
- R4: Negating a negative code never wraps around. The code -1.0 (0xC00) has magnitude 1.0 (0x400) and the code -2.0 (0x800) has magnitude 2.0, so both map to 1.
- R5: The first hidden neuron fires when the sum of the two input bits is at least 1. When neither sample is large, `y` is 0.
- R6: The second hidden neuron fires when the negated sum of the two input bits is at least -1, which it evaluates in a signed sum of at least 3 bits. When both samples are large, `y` is 0.
- R7: The output neuron fires when the sum of the two hidden outputs is at least 2. As a result, `y` is 1 exactly when one sample is large and the other is not.
- R8: If `inValid` is high at a clock edge, `outValid` is 1 after that edge and `y` holds the result for the samples taken at that edge.
- R9: If `inValid` is low at a clock edge, `outValid` is 0 after that edge and `y` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Samples on `xA` and `xB` are valid this cycle |
| xA | input | 12 | First sample, two's complement, 10 fractional bits |
| xB | input | 12 | Second sample, two's complement, 10 fractional bits |
| outValid | output | 1 | `y` was updated by the previous edge |
| y | output | 1 | Registered classification result |

## Verification
The bench builds the block with its default parameters: 12-bit samples, 10 fractional bits and a 3-bit signed neuron sum. These values make the whole sample space of one input small enough to sweep exhaustively while the other input is held at representative codes, including the ±0.5 boundaries and their inner neighbours. With these values the negation corner cases -1.0 and -2.0 are also in reach, and the NAND neuron's negative sums run all the way to -2. Idle cycles and a reset issued mid-stream exercise the hold and clear behaviour of the registered output.

// File: rtl/xorn_pkg.sv
package xorn_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture new result
    logic clear;  // reset result register
  } strobe_t;

endpackage

// File: rtl/xorn_input_node.sv
module xorn_input_node #(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 10
) (
  input  logic [DATA_W-1:0] sample,
  output logic              isLarge
);

  localparam logic [DATA_W-1:0] HALF = DATA_W'(1) << (FRAC_W - 1);

  logic [DATA_W-1:0] magnitude;

  // Sign bit selects pass-through or two's-complement negation; the
  // result is read as unsigned, so the most negative code cannot wrap.
  always_comb begin
    if (sample[DATA_W-1]) magnitude = ~sample + DATA_W'(1);
    else                  magnitude = sample;
  end

  assign isLarge = (magnitude >= HALF);

  // R4: a negative sample never yields a zero magnitude
  always_comb begin
    a_r4_no_wrap: assert (!sample[DATA_W-1] || magnitude != '0);
  end

endmodule

// File: rtl/xorn_datapath.sv
module xorn_datapath
  import xorn_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 10,
  parameter int SUM_W  = 3
) (
  input  logic              clk,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] xA,
  input  logic [DATA_W-1:0] xB,
  output logic              yReg
);

  localparam int NUM_IN = 2;
  localparam logic signed [SUM_W-1:0] THR_OR   = SUM_W'(1);
  localparam logic signed [SUM_W-1:0] THR_NAND = -SUM_W'(1);
  localparam logic signed [SUM_W-1:0] THR_OUT  = SUM_W'(2);

  logic [DATA_W-1:0] samples [NUM_IN];
  logic [NUM_IN-1:0] bits;

  assign samples[0] = xA;
  assign samples[1] = xB;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    xorn_input_node #(
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W)
    ) u_node (
      .sample (samples[i]),
      .isLarge(bits[i])
    );
  end

  // Widen the bits into signed neuron operands
  logic signed [SUM_W-1:0] wA, wB;
  assign wA = {{(SUM_W-1){1'b0}}, bits[0]};
  assign wB = {{(SUM_W-1){1'b0}}, bits[1]};

  logic signed [SUM_W-1:0] sumOr, sumNand, sumOut;
  logic signed [SUM_W-1:0] hOr, hNand;
  logic hidOr, hidNand, yNext;

  assign sumOr   = wA + wB;
  assign hidOr   = (sumOr >= THR_OR);
  assign sumNand = '0 - wA - wB;
  assign hidNand = (sumNand >= THR_NAND);

  assign hOr    = {{(SUM_W-1){1'b0}}, hidOr};
  assign hNand  = {{(SUM_W-1){1'b0}}, hidNand};
  assign sumOut = hOr + hNand;
  assign yNext  = (sumOut >= THR_OUT);

  always_ff @(posedge clk) begin
    if (stb.clear)     yReg <= 1'b0;
    else if (stb.load) yReg <= yNext;
  end

  // R5: OR-like neuron tracks the input bits
  always_comb begin
    a_r5_or_unit: assert (hidOr == (bits[0] | bits[1]));
  end

  // R6: NAND-like neuron is low only with both bits set
  always_comb begin
    a_r6_nand_unit: assert (hidNand == !(bits[0] & bits[1]));
  end

  // R7: captured result equals exclusive-or of the input bits
  a_r7_capture: assert property (@(posedge clk) disable iff (stb.clear)
    stb.load |=> yReg == $past(bits[0] ^ bits[1]));

  // R1: clear empties the result register
  a_r1_clear_y: assert property (@(posedge clk)
    stb.clear |=> !yReg);

endmodule

// File: rtl/xorn_ctrl.sv
module xorn_ctrl
  import xorn_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t stb,
  output logic    outValid
);

  always_comb begin
    stb.clear = rst;
    stb.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R1: reset clears the valid flag
  a_r1_clear_valid: assert property (@(posedge clk)
    rst |=> !outValid);

  // R8: accepted sample produces a valid flag next cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R9: no sample means no valid flag next cycle
  a_r9_idle_drop: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/xorn_classifier.sv
module xorn_classifier
  import xorn_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 10,
  parameter int SUM_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] xA,
  input  logic [DATA_W-1:0] xB,
  output logic              outValid,
  output logic              y
);

  strobe_t stb;

  xorn_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .stb     (stb),
    .outValid(outValid)
  );

  xorn_datapath #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W),
    .SUM_W (SUM_W)
  ) u_dp (
    .clk (clk),
    .stb (stb),
    .xA  (xA),
    .xB  (xB),
    .yReg(y)
  );

  // R9: result holds while no sample is taken
  a_r9_hold_y: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(y));

endmodule

// File: tb/xorn_classifier_tb.sv
module xorn_classifier_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [11:0] xA = '0;
  logic [11:0] xB = '0;
  logic        outValid;
  logic        y;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  bit    expQ [$];
  string tagQ [$];

  logic vEdge, rEdge, lastY;

  always #10 clk = ~clk;  // 50 MHz

  xorn_classifier u_dut (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .xA      (xA),
    .xB      (xB),
    .outValid(outValid),
    .y       (y)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference: magnitude of the signed code against one half
  function automatic bit bigRef(input logic [11:0] c);
    int v;
    v = int'(signed'(c));
    return (v >= 512) || (v <= -512);
  endfunction

  function automatic string pickTag(input logic [11:0] a, input logic [11:0] b, input string dflt);
    bit ba, bb;
    ba = bigRef(a);
    bb = bigRef(b);
    if (a == 12'h200 || a == 12'hE00 || a == 12'h1FF || a == 12'hE01 ||
        b == 12'h200 || b == 12'hE00 || b == 12'h1FF || b == 12'hE01) return "R3";
    if (a == 12'hC00 || a == 12'h800 || b == 12'hC00 || b == 12'h800) return "R4";
    if (dflt.len() != 0) return dflt;
    if (ba && bb) return "R6";
    if (!ba && !bb) return "R5";
    return "R7";
  endfunction

  // Driver: applies one sample pair and pushes the expected answer
  task automatic drive(input logic [11:0] a, input logic [11:0] b, input string dflt);
    @(negedge clk);
    xA = a;
    xB = b;
    inValid = 1'b1;
    expQ.push_back(bigRef(a) ^ bigRef(b));
    tagQ.push_back(pickTag(a, b, dflt));
  endtask

  task automatic idle(input logic [11:0] a, input logic [11:0] b);
    @(negedge clk);
    xA = a;
    xB = b;
    inValid = 1'b0;
  endtask

  // Monitor: pops and compares results after each edge
  always @(posedge clk) begin
    vEdge = inValid;
    rEdge = rst;
    #5;
    if (!done) begin
      if (rEdge) begin
        check(outValid == 1'b0 && y == 1'b0, "R1", {outValid, y}, 0);
        lastY = 1'b0;
      end else begin
        check(outValid == vEdge, vEdge ? "R8" : "R9", outValid, vEdge);
        if (vEdge) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R8", 1, 0);
          end else begin
            bit    e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(y == e, t, y, e);
          end
        end else begin
          check(y == lastY, "R9", y, lastY);
        end
        lastY = y;
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R3: boundary codes against a small partner and a large partner
    drive(12'h200, 12'h000, "");
    drive(12'hE00, 12'h000, "");
    drive(12'h1FF, 12'h000, "");
    drive(12'hE01, 12'h000, "");
    drive(12'h000, 12'h200, "");
    drive(12'h1FF, 12'h300, "");
    drive(12'h200, 12'hE00, "");
    drive(12'hE01, 12'h1FF, "");

    // R4: most negative codes
    drive(12'hC00, 12'h000, "");
    drive(12'h800, 12'h000, "");
    drive(12'hC00, 12'h400, "");
    drive(12'h800, 12'h7FF, "");

    // R5 / R6 / R7: representative pairs
    drive(12'h000, 12'h100, "");
    drive(12'h3FF, 12'hFFF, "");
    drive(12'hF00, 12'h400, "");
    drive(12'h400, 12'h001, "");

    // R9: idle cycles with changing inputs
    idle(12'h000, 12'h400);
    idle(12'hC00, 12'h000);
    drive(12'h000, 12'h000, "");
    idle(12'h400, 12'h000);

    // R2: full sweep of xA with a zero partner, then other partners
    for (int i = 0; i < 4096; i++) drive(12'(i), 12'h000, "R2");
    for (int i = 0; i < 4096; i++) begin
      drive(12'(i), 12'h400, "");
      if (i % 97 == 0) idle(12'(i), 12'h000);
    end
    for (int i = 0; i < 4096; i++) drive(12'(i), 12'hE00, "");
    for (int i = 0; i < 4096; i++) drive(12'(i), 12'h1FF, "");
    for (int i = 0; i < 4096; i++) drive(12'h000, 12'(i), "");
    for (int i = 0; i < 4096; i++) drive(12'hC00, 12'(i), "");

    // R1: reset in the middle of traffic
    drive(12'h400, 12'h000, "");
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    xA = 12'h400;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    idle(12'h000, 12'h000);
    drive(12'h000, 12'h600, "");
    idle(12'h000, 12'h000);
    repeat (3) @(negedge clk);

    if (expQ.size() != 0) check(1'b0, "R8", expQ.size(), 0);
    finishRun();
  end

endmodule